// File: doc/BRIEF.md
# Secondary-Bus Initiator Latency Timer

This block bounds how long a bridge may keep ownership of its secondary bus once it has started a transaction there as initiator. Software programs an 8-bit limit, counted in bus clock cycles, through a byte-wide configuration port that decodes a single register address. When the bridge begins a transaction, it pulses `frame_start`. The block then counts clock cycles from zero and raises `expired` once the count reaches the programmed limit.

Expiry alone does not cut the transaction short. The block asks for termination only when the timer has expired, the transaction is still running, and the internal `grant` has been withdrawn, which happens because another secondary-bus master wants the bus. That request, `term_req`, lasts a single cycle. The block then waits for `xfer_done`, which clears the count and returns it to idle.

The controller has three states. ST_IDLE means no transaction is running. ST_RUN means a transaction is running and termination has not been requested. ST_YIELD means termination has been requested and the block is waiting for the end of the transaction. The transitions are as follows:

- START (ST_IDLE to ST_RUN) happens on `frame_start`.
- FINISH (ST_RUN to ST_IDLE) happens on `xfer_done`.
- YIELD (ST_RUN to ST_YIELD) happens on the cycle where the timer is expired, `grant` is low and `xfer_done` is low. `term_req` is asserted on that cycle.
- RELEASE (ST_YIELD to ST_IDLE) happens on `xfer_done`.

Top module: `lt_master_timer`

## Requirements
- R1: After reset the limit register reads 00h, and both `expired` and `term_req` are low.
- R2: The limit register sits at address 1Bh. A write with `cfg_we` high at that address stores `cfg_wdata`, and reads at that address return the stored value. A write to any other address leaves the register unchanged, and a read of any other address returns 00h.
- R3: A `frame_start` sampled in ST_IDLE loads the count with zero. Each following clock edge adds one. `expired` goes high after the edge at which the count equals the limit L, which is L edges after the starting edge, and it stays high while the transaction runs.
- R4: With a limit of zero, `expired` is high right after the starting edge.
- R5: Once the limit is reached, the count saturates and never wraps. With L = 255, `expired` stays high for an arbitrarily long transaction.
- R6: `term_req` is high only while `expired` is high, the transaction is active, and `grant` is low. It is never high while `grant` is high, however long the transaction lasts.
- R7: `term_req` is a one-cycle pulse. It stays low for the rest of that transaction, even if `grant` returns and is withdrawn again.
- R8: `xfer_done` ends the transaction. The count clears, `expired` is low after that edge, and `term_req` is low during a cycle in which `xfer_done` is high.
- R9: A `frame_start` after completion restarts the count from zero.
- R10: A `frame_start` during an active transaction is ignored and does not restart the count.
- R11: If `grant` is withdrawn before expiry, `term_req` waits for the first expired cycle and fires there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| frame_start | input | 1 | Bridge begins a transaction as initiator |
| grant | input | 1 | Internal bus grant; low means another master wants the bus |
| xfer_done | input | 1 | Current transaction has ended |
| expired | output | 1 | Timer has reached the limit during an active transaction |
| term_req | output | 1 | One-cycle request to terminate the transaction |

## Verification
The hardest situation to reach from the ports is the long run past saturation. To get there, the limit is set to 255, the transaction is held for 300 cycles with the grant held, and each cycle checks that `expired` never drops and `term_req` never rises. A second hard case is the cycle in which grant loss and completion coincide. The stimulus reaches it by first parking the block in an expired, granted transaction, then lowering `grant` and raising `xfer_done` at the same moment. Revoking the grant after the pulse and then restarting the frame mid-transaction exercise the ST_YIELD state and the ignored START.

// File: rtl/lt_pkg.sv
package lt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_YIELD = 2'd2
    } lt_state_t;
endpackage

// File: rtl/lt_cfg_reg.sv
module lt_cfg_reg #(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  OFFSET = 8'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] limit
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

    logic sel;
    assign sel = (addr == HIT_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            limit <= '0;
        else if (we && sel)
            limit <= wdata;
    end

    assign rdata = sel ? limit : '0;

    // R2: register only changes on a decoded write
    assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel) |=> $stable(limit));
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (step && (count < limit))
            count <= count + CNT_W'(1);
    end

    assign hit = (count >= limit);

    // R5: without a clear the count never goes down (no wrap)
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count >= $past(count));
    // R3: a clear always yields a zero count
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/lt_ctrl_fsm.sv
module lt_ctrl_fsm
    import lt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic grant,
    input  logic xfer_done,
    input  logic hit,
    output logic active,
    output logic clr,
    output logic step,
    output logic term_req
);
    lt_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        clr      = 1'b0;
        step     = 1'b0;
        term_req = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (frame_start) begin          // START
                    clr      = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (xfer_done) begin            // FINISH
                    clr      = 1'b1;
                    state_nx = ST_IDLE;
                end else if (hit && !grant) begin // YIELD
                    term_req = 1'b1;
                    state_nx = ST_YIELD;
                end else begin
                    step = 1'b1;
                end
            end
            ST_YIELD: begin
                if (xfer_done) begin            // RELEASE
                    clr      = 1'b1;
                    state_nx = ST_IDLE;
                end else begin
                    step = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign active = (state != ST_IDLE);

    // R6: no termination while grant is held
    assert_no_term_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |-> (!grant && hit));
    // R7: termination is a single-cycle pulse
    assert_term_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |=> !term_req);
    // R8: completion never coincides with termination
    assert_done_no_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !term_req);
endmodule

// File: rtl/lt_master_timer.sv
module lt_master_timer #(
    parameter int         LAT_W  = 8,
    parameter int         ADDR_W = 8,
    parameter logic [7:0] REG_OFFSET = 8'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [LAT_W-1:0]  cfg_wdata,
    output logic [LAT_W-1:0]  cfg_rdata,
    input  logic              frame_start,
    input  logic              grant,
    input  logic              xfer_done,
    output logic              expired,
    output logic              term_req
);
    logic [LAT_W-1:0] limit;
    logic hit, active, clr, step;

    lt_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(LAT_W), .OFFSET(REG_OFFSET)) u_reg (
        .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .we(cfg_we),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .limit(limit)
    );

    lt_counter #(.CNT_W(LAT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
        .limit(limit), .hit(hit)
    );

    lt_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .grant(grant),
        .xfer_done(xfer_done), .hit(hit), .active(active), .clr(clr),
        .step(step), .term_req(term_req)
    );

    assign expired = active && hit;

    // R8: a finished transaction leaves the timer unexpired
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && active) |=> !expired);
    // R6: termination only during an expired transaction
    assert_term_expired_R6: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |-> expired);
endmodule

// File: tb/tb_lt_master_timer.sv
module tb_lt_master_timer;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       frame_start = 1'b0;
    logic       grant = 1'b1;
    logic       xfer_done = 1'b0;
    logic       expired;
    logic       term_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    lt_master_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
        .grant(grant), .xfer_done(xfer_done), .expired(expired), .term_req(term_req)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_limit(input logic [7:0] a, input logic [7:0] v);
        cfg_addr = a; cfg_wdata = v; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0; cfg_addr = 8'h1B;
        #1;
    endtask

    task automatic start_frame();
        frame_start = 1'b1;
        tick(1);
        frame_start = 1'b0;
        #1;
    endtask

    task automatic finish_txn();
        xfer_done = 1'b1;
        tick(1);
        xfer_done = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        cfg_addr = 8'h1B; #1;
        check("R1 limit", cfg_rdata, 0);
        check("R1 expired", expired, 0);
        check("R1 term_req", term_req, 0);
    endtask

    task automatic t_register();
        write_limit(8'h1B, 8'hA5);
        check("R2 readback", cfg_rdata, 8'hA5);
        write_limit(8'h1A, 8'h3C);
        check("R2 other write ignored", cfg_rdata, 8'hA5);
        cfg_addr = 8'h19; #1;
        check("R2 other read zero", cfg_rdata, 0);
        cfg_addr = 8'h1B; #1;
    endtask

    task automatic t_count(input int lim, input string tag);
        write_limit(8'h1B, 8'(lim));
        grant = 1'b1;
        start_frame();
        for (int k = 0; k <= lim + 2; k++) begin
            check(tag, expired, (k >= lim) ? 1 : 0);
            check("R6 granted no term", term_req, 0);
            tick(1);
        end
        finish_txn();
        check("R8 cleared", expired, 0);
    endtask

    task automatic t_saturate();
        write_limit(8'h1B, 8'd255);
        grant = 1'b1;
        start_frame();
        tick(254);
        check("R5 before limit", expired, 0);
        for (int k = 0; k < 300; k++) begin
            tick(1);
            check("R5 saturated", expired, 1);
            check("R6 long granted", term_req, 0);
        end
        finish_txn();
    endtask

    task automatic t_terminate();
        write_limit(8'h1B, 8'd2);
        grant = 1'b1;
        start_frame();
        tick(5);
        check("R6 held grant", term_req, 0);
        grant = 1'b0; #1;
        check("R6 term on grant loss", term_req, 1);
        tick(1);
        check("R7 pulse ends", term_req, 0);
        grant = 1'b1; tick(1);
        grant = 1'b0; #1;
        check("R7 no second pulse", term_req, 0);
        tick(2);
        check("R7 still low", term_req, 0);
        check("R7 expired kept", expired, 1);
        grant = 1'b1;
        finish_txn();
        check("R8 idle after yield", expired, 0);
    endtask

    task automatic t_done_collide();
        write_limit(8'h1B, 8'd1);
        grant = 1'b1;
        start_frame();
        tick(2);
        grant = 1'b0; xfer_done = 1'b1; #1;
        check("R8 done blocks term", term_req, 0);
        tick(1);
        xfer_done = 1'b0; #1;
        check("R8 expired cleared", expired, 0);
        check("R8 no term in idle", term_req, 0);
        grant = 1'b1;
    endtask

    task automatic t_restart();
        write_limit(8'h1B, 8'd3);
        start_frame();
        tick(5);
        finish_txn();
        start_frame();
        tick(2);
        check("R9 restart from zero", expired, 0);
        tick(1);
        check("R9 expires at limit", expired, 1);
        finish_txn();
    endtask

    task automatic t_ignore_start();
        write_limit(8'h1B, 8'd5);
        start_frame();
        tick(3);
        start_frame();
        check("R10 mid start", expired, 0);
        tick(1);
        check("R10 no restart", expired, 1);
        finish_txn();
    endtask

    task automatic t_early_loss();
        write_limit(8'h1B, 8'd3);
        grant = 1'b0;
        start_frame();
        check("R11 no early term", term_req, 0);
        tick(2);
        check("R11 still waiting", term_req, 0);
        tick(1);
        check("R11 term at expiry", term_req, 1);
        tick(1);
        check("R11 single", term_req, 0);
        grant = 1'b1;
        finish_txn();
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_register();
        t_count(3, "R3 count to limit");
        t_count(0, "R4 zero limit");
        t_saturate();
        t_terminate();
        t_done_collide();
        t_restart();
        t_ignore_start();
        t_early_loss();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule